// File: doc/BRIEF.md
# Short Inter-Frame Gap Rate Limiter

A transmitter may close up the idle time between two packets and send the next one after a shortened gap. Sending every packet that way would push the packet rate above the rate the link allows. This block decides, packet by packet, whether the packet now starting may use the short gap or must fall back to the normal gap. It runs on the wire-side clock. It samples a short-gap enable, a limit enable and the packet's own short-gap request on a packet-start strobe. The registered grant it produces holds for the whole packet.

With limiting switched on, each granted short-gap packet arms a hold-off counter with `RELOAD` (10,000 by default). The counter counts down by one on every clock. While it is non-zero, any short-gap request is refused and that packet goes out with the normal gap. This keeps short-gap packets to roughly one per 10,000 clocks, about 100 ppm. With limiting switched off, the counter plays no part and is never armed.

Top module: `sgap_limiter`

## Requirements
- R1: A packet start with the short-gap enable at 0 gives grant 0 (normal gap), whatever the other inputs are.
- R2: A packet start with no short-gap request gives grant 0.
- R3: With the limit enable at 0, every start that has both the enable and the request is granted, including starts on consecutive clocks. Such grants do not arm the hold-off counter, so a request made right after limiting is switched on is granted.
- R4: With the limit enable at 1, a granted start loads the hold-off counter with `RELOAD` on the same clock edge that captures the grant.
- R5: The hold-off counter decreases by one on every clock while it is non-zero, and it stays at zero once it gets there.
- R6: With the limit enable at 1, a start captured while the counter is non-zero (that is, 1 to `RELOAD` edges after a granted start) gives grant 0. Such a refused start does not reload the counter.
- R7: With the limit enable at 1, a start captured `RELOAD`+1 or more edges after the last granted start is granted.
- R8: The grant is a register. It takes its new value on the edge that samples the packet-start strobe and keeps that value until the next strobe.
- R9: After reset the grant is 0 and the counter is 0, so the first qualifying request is granted even with limiting on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sgap_en | input | 1 | Permits short gaps at all |
| limit_en | input | 1 | Turns on the hold-off rate limit |
| sgap_req | input | 1 | The starting packet asks for a short gap |
| pkt_start | input | 1 | One-clock strobe marking a packet start |
| sgap_grant | output | 1 | 1: the current packet uses the short gap; 0: normal gap |

## Verification
Each grant decision is due one clock edge after its strobe. The bench raises the strobe on a falling edge and reads the grant on the next falling edge, so the capturing rising edge always lies between the two. The limit window is measured in rising edges counted from a granted start. The bench places strobes exactly `RELOAD` edges later (expected refused) and `RELOAD`+1 edges later (expected granted), so an off-by-one in the load or the zero test shows up directly. Held-grant checks are read after idle stretches of several clocks.

// File: rtl/sgap_pkg.sv
package sgap_pkg;
  localparam int unsigned DEF_RELOAD = 10000;

  typedef enum logic {
    GAP_NORMAL = 1'b0,
    GAP_SHORT  = 1'b1
  } gap_sel_e;
endpackage

// File: rtl/sgap_holdoff.sv
module sgap_holdoff #(
  parameter int unsigned RELOAD = sgap_pkg::DEF_RELOAD,
  localparam int unsigned CNT_W = $clog2(RELOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic idle
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = arm || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (arm)               cnt_d = CNT_W'(RELOAD);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> cnt_q == CNT_W'(RELOAD));
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/sgap_gate.sv
module sgap_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sgap_en,
  input  logic limit_en,
  input  logic sgap_req,
  input  logic pkt_start,
  input  logic hold_idle,
  output logic arm,
  output logic grant
);
  import sgap_pkg::*;

  gap_sel_e sel_q, sel_d;
  logic     allow;

  always_comb begin
    allow = sgap_en && sgap_req && (!limit_en || hold_idle);
    sel_d = allow ? GAP_SHORT : GAP_NORMAL;
    arm   = pkt_start && allow && limit_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= GAP_NORMAL;
    else if (pkt_start) sel_q <= sel_d;
  end

  assign grant = (sel_q == GAP_SHORT);

  a_r1_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !sgap_en) |=> !grant);
  a_r2_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !sgap_req) |=> !grant);
  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && limit_en && !hold_idle) |=> !grant);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_start |=> $stable(grant));
endmodule

// File: rtl/sgap_limiter.sv
module sgap_limiter #(
  parameter int unsigned RELOAD = sgap_pkg::DEF_RELOAD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sgap_en,
  input  logic limit_en,
  input  logic sgap_req,
  input  logic pkt_start,
  output logic sgap_grant
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       arm;
  logic       hold_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sgap_holdoff #(.RELOAD(RELOAD)) u_holdoff (
    .clk   (clk),
    .rst_n (rst_n_int),
    .arm   (arm),
    .idle  (hold_idle)
  );

  sgap_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sgap_en   (sgap_en),
    .limit_en  (limit_en),
    .sgap_req  (sgap_req),
    .pkt_start (pkt_start),
    .hold_idle (hold_idle),
    .arm       (arm),
    .grant     (sgap_grant)
  );

  a_r3_unlimited: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pkt_start && sgap_en && sgap_req && !limit_en) |=> sgap_grant);
  a_r9_reset_grant: assert property (@(posedge clk)
    !rst_n_int |-> !sgap_grant);
endmodule

// File: tb/sgap_limiter_bench.sv
module sgap_limiter_bench;
  localparam int unsigned RELOAD = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sgap_en = 1'b0, limit_en = 1'b0, sgap_req = 1'b0, pkt_start = 1'b0;
  logic sgap_grant;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sgap_limiter #(.RELOAD(RELOAD)) u_sgap_limiter (
    .clk(clk), .rst_n(rst_n), .sgap_en(sgap_en), .limit_en(limit_en),
    .sgap_req(sgap_req), .pkt_start(pkt_start), .sgap_grant(sgap_grant)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (sgap_grant !== exp) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", req, sgap_grant, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe captured at the next rising edge; grant read on the falling edge after it.
  task automatic start(input logic en, input logic lim, input logic req,
                       input string tag, input logic exp);
    sgap_en = en; limit_en = lim; sgap_req = req; pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    check(tag, exp);
  endtask

  task automatic t_reset;
    check("R9 reset grant", 1'b0);
    start(1, 1, 1, "R9 first request granted", 1'b1);
    idle(5);
    check("R8 grant held", 1'b1);
    idle(RELOAD);
  endtask

  task automatic t_qualifiers;
    start(0, 0, 1, "R1 enable off", 1'b0);
    start(1, 0, 1, "R3 grant", 1'b1);
    start(1, 0, 0, "R2 no request", 1'b0);
    idle(3);
    check("R8 refusal held", 1'b0);
    start(0, 1, 1, "R1 enable off, limit on", 1'b0);
  endtask

  task automatic t_unlimited;
    for (int i = 0; i < 4; i++) start(1, 0, 1, "R3 back-to-back", 1'b1);
    start(1, 1, 1, "R3 no arm while unlimited", 1'b1);
    idle(RELOAD);
  endtask

  task automatic t_window;
    start(1, 1, 1, "R4 arming grant", 1'b1);
    idle(RELOAD - 1);
    start(1, 1, 1, "R6 refused at RELOAD edges", 1'b0);
    start(1, 1, 1, "R7 granted at RELOAD+1 edges", 1'b1);
    idle(RELOAD - 1);
    start(1, 1, 1, "R4 R5 reload refused", 1'b0);
    idle(RELOAD);
  endtask

  task automatic t_no_reload;
    start(1, 1, 1, "R4 arm", 1'b1);
    idle(4999);
    start(1, 1, 1, "R6 refused mid-window", 1'b0);
    idle(RELOAD - 5000);
    start(1, 1, 1, "R6 R7 refusal did not reload", 1'b1);
    idle(2);
    start(1, 1, 1, "R6 early refused", 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_qualifiers();
    t_unlimited();
    t_window();
    t_no_reload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule